// File: doc/BRIEF.md
# Shared Single-Line Bus Exchange

This block passes one bit at a time across a single shared bus line. Two transmitter groups, A and C, each have four 1-bit channels. Each group has a 4-to-1 selector with a 2-bit select, and its selected channel goes to the bus through a switchable driver. Two receiver groups, B and D, each have four 1-bit outputs. Each is fed from the bus by a 1-to-4 router with its own 2-bit select. The exchange is purely combinational. A transfer is set entirely by the four selects and the two driver enables.

The line has one legal driver at a time. When exactly one enable is high, that group's selected channel appears on the bus. It then reaches the selected output of each receiver group. When both enables are high, the drivers would fight, so the contention flag rises and every receiver is held low. When neither enable is high, the line floats, so the idle flag rises and every receiver is held low. In both of these states the observable bus value reads 0, and the matching flag says why.

Top module: `shared_bus_xchg`

## Requirements
- R1: With enA=1 and enC=0, busBit equals txA bit number selA (select value 2'b00 picks bit 0, 2'b11 picks bit 3).
- R2: With enC=1 and enA=0, busBit equals txC bit number selC, using the same index encoding.
- R3: With exactly one enable high, rxB has only bit number selB set, and only when busBit is 1. Every other rxB bit is 0.
- R4: With exactly one enable high, rxD has only bit number selD set, and only when busBit is 1. Every other rxD bit is 0.
- R5: With enA=1 and enC=1, busContend=1, busIdle=0, busBit=0, and rxB and rxD are all 0.
- R6: With enA=0 and enC=0, busIdle=1, busContend=0, busBit=0, and rxB and rxD are all 0.
- R7: The data and select of the disabled transmitter group have no effect on busBit, rxB or rxD.
- R8: Sending A3 to B1 uses selA=2'b11, selB=2'b01, enA=1 and enC=0. rxB[1] then follows txA[3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| txA | input | 4 | Group A transmitter channels |
| txC | input | 4 | Group C transmitter channels |
| selA | input | 2 | Channel index for group A selector |
| selC | input | 2 | Channel index for group C selector |
| selB | input | 2 | Output index for group B router |
| selD | input | 2 | Output index for group D router |
| enA | input | 1 | Enables group A driver onto the bus |
| enC | input | 1 | Enables group C driver onto the bus |
| rxB | output | 4 | Group B receiver outputs |
| rxD | output | 4 | Group D receiver outputs |
| busBit | output | 1 | Resolved bus value, 0 unless exactly one driver is on |
| busContend | output | 1 | Both drivers enabled |
| busIdle | output | 1 | No driver enabled |

## Verification
The block has no stored state, so a fault appears at the ports in the same settle time as the stimulus. A wrong selector index shows up as busBit copying a different channel. A wrong router index shows up as a set bit at the wrong receiver position, or as more than one bit set. A mistake in the enable decode shows up as receivers active during contention or idle, or as a wrong flag. The sweep covers every enable pattern, every combination of the four selects and every data value. A fault is therefore exposed at the first vector that touches it.

// File: rtl/shared_bus_xchg_pkg.sv
package shared_bus_xchg_pkg;
  typedef struct packed {
    logic passA;
    logic passC;
    logic contend;
    logic idle;
  } drvStrobe_t;
endpackage

// File: rtl/xchg_ctrl.sv
module xchg_ctrl
  import shared_bus_xchg_pkg::*;
(
  input  logic       enA,
  input  logic       enC,
  output drvStrobe_t strobe
);
  always_comb begin
    strobe.passA   = enA & ~enC;
    strobe.passC   = enC & ~enA;
    strobe.contend = enA & enC;
    strobe.idle    = ~enA & ~enC;
  end

  always_comb begin
    // R5
    one_state_chk: assert ($onehot({strobe.passA, strobe.passC, strobe.contend, strobe.idle}));
    // R6
    idle_enables_chk: assert (!strobe.idle || (!enA && !enC));
  end
endmodule

// File: rtl/xchg_sel_mux.sv
module xchg_sel_mux #(
  parameter int CHANNELS = 4,
  localparam int SEL_W = $clog2(CHANNELS)
) (
  input  logic [CHANNELS-1:0] dataIn,
  input  logic [SEL_W-1:0]    sel,
  output logic                dataOut
);
  logic [CHANNELS-1:0] gated;

  generate
    for (genvar i = 0; i < CHANNELS; i++) begin : g_and
      assign gated[i] = dataIn[i] & (sel == SEL_W'(i));
    end
  endgenerate

  assign dataOut = |gated;
endmodule

// File: rtl/xchg_sel_demux.sv
module xchg_sel_demux #(
  parameter int CHANNELS = 4,
  localparam int SEL_W = $clog2(CHANNELS)
) (
  input  logic                dataIn,
  input  logic                valid,
  input  logic [SEL_W-1:0]    sel,
  output logic [CHANNELS-1:0] dataOut
);
  generate
    for (genvar i = 0; i < CHANNELS; i++) begin : g_route
      assign dataOut[i] = dataIn & valid & (sel == SEL_W'(i));
    end
  endgenerate

  always_comb begin
    // R3
    route_onehot_chk: assert ($onehot0(dataOut));
    // R6
    route_blocked_chk: assert (valid || dataOut == '0);
  end
endmodule

// File: rtl/xchg_datapath.sv
module xchg_datapath
  import shared_bus_xchg_pkg::*;
#(
  parameter int CHANNELS = 4,
  localparam int SEL_W = $clog2(CHANNELS)
) (
  input  drvStrobe_t          strobe,
  input  logic [CHANNELS-1:0] txA,
  input  logic [CHANNELS-1:0] txC,
  input  logic [SEL_W-1:0]    selA,
  input  logic [SEL_W-1:0]    selC,
  input  logic [SEL_W-1:0]    selB,
  input  logic [SEL_W-1:0]    selD,
  output logic [CHANNELS-1:0] rxB,
  output logic [CHANNELS-1:0] rxD,
  output logic                busBit
);
  logic muxA, muxC, lineValid;

  xchg_sel_mux #(.CHANNELS(CHANNELS)) u_muxA (.dataIn(txA), .sel(selA), .dataOut(muxA));
  xchg_sel_mux #(.CHANNELS(CHANNELS)) u_muxC (.dataIn(txC), .sel(selC), .dataOut(muxC));

  assign lineValid = strobe.passA | strobe.passC;
  assign busBit    = (strobe.passA & muxA) | (strobe.passC & muxC);

  xchg_sel_demux #(.CHANNELS(CHANNELS)) u_demuxB (
    .dataIn(busBit), .valid(lineValid), .sel(selB), .dataOut(rxB));
  xchg_sel_demux #(.CHANNELS(CHANNELS)) u_demuxD (
    .dataIn(busBit), .valid(lineValid), .sel(selD), .dataOut(rxD));

  always_comb begin
    // R1
    a_drive_chk: assert (!strobe.passA || busBit == muxA);
    // R2
    c_drive_chk: assert (!strobe.passC || busBit == muxC);
    // R5
    no_drive_chk: assert (lineValid || busBit == 1'b0);
  end
endmodule

// File: rtl/shared_bus_xchg.sv
module shared_bus_xchg
  import shared_bus_xchg_pkg::*;
#(
  parameter int CHANNELS = 4,
  localparam int SEL_W = $clog2(CHANNELS)
) (
  input  logic [CHANNELS-1:0] txA,
  input  logic [CHANNELS-1:0] txC,
  input  logic [SEL_W-1:0]    selA,
  input  logic [SEL_W-1:0]    selC,
  input  logic [SEL_W-1:0]    selB,
  input  logic [SEL_W-1:0]    selD,
  input  logic                enA,
  input  logic                enC,
  output logic [CHANNELS-1:0] rxB,
  output logic [CHANNELS-1:0] rxD,
  output logic                busBit,
  output logic                busContend,
  output logic                busIdle
);
  drvStrobe_t strobe;

  xchg_ctrl u_ctrl (.enA(enA), .enC(enC), .strobe(strobe));

  xchg_datapath #(.CHANNELS(CHANNELS)) u_dp (
    .strobe(strobe), .txA(txA), .txC(txC),
    .selA(selA), .selC(selC), .selB(selB), .selD(selD),
    .rxB(rxB), .rxD(rxD), .busBit(busBit)
  );

  assign busContend = strobe.contend;
  assign busIdle    = strobe.idle;
endmodule

// File: tb/shared_bus_xchg_bench.sv
module shared_bus_xchg_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] txA, txC, rxB, rxD;
  logic [1:0] selA, selC, selB, selD;
  logic enA, enC, busBit, busContend, busIdle;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  shared_bus_xchg u_shared_bus_xchg (
    .txA(txA), .txC(txC), .selA(selA), .selC(selC), .selB(selB), .selD(selD),
    .enA(enA), .enC(enC), .rxB(rxB), .rxD(rxD), .busBit(busBit),
    .busContend(busContend), .busIdle(busIdle)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (enA=%0d enC=%0d selA=%0d selC=%0d selB=%0d selD=%0d txA=%0d txC=%0d)",
               req, act, exp, enA, enC, selA, selC, selB, selD, txA, txC);
    end
  endtask

  task automatic applyAndCheck();
    int bitExp, rxBExp, rxDExp, cont, idl, one;
    #2;
    cont = (enA && enC) ? 1 : 0;
    idl  = (!enA && !enC) ? 1 : 0;
    one  = (enA != enC) ? 1 : 0;
    bitExp = enA && !enC ? ((txA >> selA) & 1) :
             enC && !enA ? ((txC >> selC) & 1) : 0;
    rxBExp = one ? (bitExp << selB) : 0;
    rxDExp = one ? (bitExp << selD) : 0;
    if (enA && !enC) check("R1 busBit", busBit, bitExp);
    else if (enC && !enA) check("R2 busBit", busBit, bitExp);
    else if (cont) check("R5 busBit", busBit, 0);
    else check("R6 busBit", busBit, 0);
    if (one) begin
      check("R3 rxB", rxB, rxBExp);
      check("R4 rxD", rxD, rxDExp);
    end else begin
      check(cont ? "R5 rxB" : "R6 rxB", rxB, 0);
      check(cont ? "R5 rxD" : "R6 rxD", rxD, 0);
    end
    check("R5 busContend", busContend, cont);
    check("R6 busIdle", busIdle, idl);
    #3;
  endtask

  initial begin
    txA = 0; txC = 0; selA = 0; selB = 0; selC = 0; selD = 0; enA = 0; enC = 0;
    #1;
    // Start state with all inputs low: idle
    applyAndCheck();
    // Exhaustive sweep of enables, selects and data
    for (int en = 0; en < 4; en++)
      for (int s = 0; s < 256; s++)
        for (int d = 0; d < 256; d++) begin
          {enA, enC} = en[1:0];
          {selA, selB, selC, selD} = s[7:0];
          {txA, txC} = d[7:0];
          applyAndCheck();
        end
    // R8: A3 to B1, both data values
    for (int v = 0; v < 2; v++) begin
      enA = 1; enC = 0; selA = 2'b11; selB = 2'b01; txA = v[0] ? 4'b1000 : 4'b0111;
      #2;
      check("R8 rxB[1]", rxB[1], v);
      check("R8 rxB", rxB, v ? 2 : 0);
      #3;
    end
    // R7: disabled C group varied while A drives a fixed value
    enA = 1; enC = 0; selA = 2'd2; txA = 4'b0100; selB = 2'd0; selD = 2'd3;
    for (int k = 0; k < 64; k++) begin
      {txC, selC} = k[5:0];
      #2;
      check("R7 busBit", busBit, 1);
      check("R7 rxB", rxB, 1);
      check("R7 rxD", rxD, 8);
      #3;
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule